// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A global history register holds the outcomes of the most recently resolved branches. A table of 2-bit saturating counters holds the learned bias for each pattern. The table is addressed by XOR-ing word-address bits of the branch PC with the history, so the history and the address share every index bit.

The fetch stage presents a PC on the lookup side. Without waiting for a clock edge, it receives a taken/not-taken guess and the table index that produced it, and it keeps that index alongside the branch. When the branch resolves, the pipeline returns the saved index and the real outcome on the update side. On that clock edge the counter at the index is trained and the outcome is shifted into the history.

Top module: `gshare_predictor`

## Requirements
- R1: After reset the history register is all zeros. Every table entry at an even index holds 01 (predict not taken), and every entry at an odd index holds 10 (predict taken).
- R2: The lookup index is PC bits [HIST_BITS+1:2] XOR the history. PC bits [1:0], and the bits above HIST_BITS+1, have no effect on the index.
- R3: The prediction is the most significant bit of the counter at the lookup index: 1 means taken, 0 means not taken.
- R4: A valid update with outcome taken raises the counter at the update index by one. A counter already at 11 stays at 11.
- R5: A valid update with outcome not taken lowers the counter at the update index by one. A counter already at 00 stays at 00. The low bit only adds hysteresis, so a counter at 00 still predicts not taken after one taken update.
- R6: Each valid update shifts the history left by one and places the outcome in bit 0, with 1 for taken and 0 for not taken.
- R7: While the update-valid input is low, neither the history nor any counter changes, whatever the other update inputs are.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the value that entry held before the update.
- R9: An update changes only the counter at its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | PC of the branch being fetched |
| predTaken | output | 1 | Predicted direction: 1 means taken |
| predIdx | output | HIST_BITS | Table index used for this prediction |
| updValid | input | 1 | A resolved branch is presented for training |
| updTaken | input | 1 | Actual outcome of the resolved branch |
| updIdx | input | HIST_BITS | Index saved at lookup time for this branch |

## Verification
The hardest state to reach from the ports is a chosen counter driven to its saturation limits. Every update also shifts the history, so the PC that reaches a fixed entry changes after each update. The bench therefore tracks the history in its own model and computes, for each step, the PC that maps onto the target entry. This lets it train one entry repeatedly past 11 and past 00 and then read back the hysteresis. Directed steps also put the lookup and the update on the same entry in one cycle, and random traffic with a fixed seed covers the remaining cases.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef struct packed {
    logic ctrWrite;
    logic ctrUp;
    logic histShift;
    logic histBit;
  } gshareStrobes_t;
endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic           updValid,
  input  logic           updTaken,
  output gshareStrobes_t strobes
);
  always_comb begin
    strobes           = '0;
    strobes.ctrWrite  = updValid;
    strobes.ctrUp     = updValid & updTaken;
    strobes.histShift = updValid;
    strobes.histBit   = updTaken;
  end
endmodule

// File: rtl/gshare_datapath.sv
module gshare_datapath
  import gshare_pkg::*;
#(
  parameter int HIST_BITS = 8,
  parameter int PC_W      = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      lookupPc,
  input  gshareStrobes_t       strobes,
  input  logic [HIST_BITS-1:0] updIdx,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predIdx,
  output logic [1:0]           updCtrNow
);
  localparam int DEPTH  = 1 << HIST_BITS;
  localparam int IDX_HI = HIST_BITS + 1;

  logic [HIST_BITS-1:0]    histQ;
  logic [DEPTH-1:0][1:0]   ctrAll;
  logic [1:0]              ctrNext;
  logic                    unusedPcBits;

  // word-aligned instructions: the two lowest PC bits carry no information
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[1:0]};

  assign predIdx   = lookupPc[IDX_HI:2] ^ histQ;
  assign predTaken = ctrAll[predIdx][1];
  assign updCtrNow = ctrAll[updIdx];

  always_comb begin
    if (strobes.ctrUp)
      ctrNext = (updCtrNow == 2'b11) ? 2'b11 : updCtrNow + 2'd1;
    else
      ctrNext = (updCtrNow == 2'b00) ? 2'b00 : updCtrNow - 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      histQ <= '0;
    else if (strobes.histShift)
      histQ <= {histQ[HIST_BITS-2:0], strobes.histBit};
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam logic [1:0] INIT = (e % 2 == 1) ? 2'b10 : 2'b01;
    logic [1:0] ctrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrQ <= INIT;
      else if (strobes.ctrWrite && (updIdx == HIST_BITS'(e)))
        ctrQ <= ctrNext;
    end
    assign ctrAll[e] = ctrQ;
  end
endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_BITS = 8,
  parameter int PC_W      = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      lookupPc,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predIdx,
  input  logic                 updValid,
  input  logic                 updTaken,
  input  logic [HIST_BITS-1:0] updIdx
);
  gshareStrobes_t strobes;
  logic [1:0]     updCtrNow;

  gshare_ctrl ctrl_i (
    .updValid (updValid),
    .updTaken (updTaken),
    .strobes  (strobes)
  );

  gshare_datapath #(.HIST_BITS(HIST_BITS), .PC_W(PC_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .lookupPc  (lookupPc),
    .strobes   (strobes),
    .updIdx    (updIdx),
    .predTaken (predTaken),
    .predIdx   (predIdx),
    .updCtrNow (updCtrNow)
  );
endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
  parameter int HIST_BITS = 8,
  parameter int PC_W      = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [PC_W-1:0]      lookupPc,
  input logic                 predTaken,
  input logic [HIST_BITS-1:0] predIdx,
  input logic                 updValid,
  input logic                 updTaken,
  input logic [HIST_BITS-1:0] updIdx,
  input logic [1:0]           updCtrNow
);
  logic [HIST_BITS-1:0] histSeen;
  logic                 pastOk;

  // history recovered from the lookup side: index XOR PC word bits
  assign histSeen = predIdx ^ lookupPc[HIST_BITS+1:2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  a_r1_hist_clear: assert property (@(posedge clk) disable iff (!rstN)
    !pastOk |-> histSeen == '0);

  a_r6_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && updValid) |=> histSeen == {$past(histSeen[HIST_BITS-2:0]), $past(updTaken)});

  a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !updValid) |=> histSeen == $past(histSeen));

  a_r3_pred_msb: assert property (@(posedge clk) disable iff (!rstN)
    (predIdx == updIdx) |-> predTaken == updCtrNow[1]);

  a_r4_sat_up: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && updValid && updTaken) |=>
      (updIdx != $past(updIdx)) ||
      (updCtrNow == (($past(updCtrNow) == 2'b11) ? 2'b11 : $past(updCtrNow) + 2'd1)));

  a_r5_sat_down: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && updValid && !updTaken) |=>
      (updIdx != $past(updIdx)) ||
      (updCtrNow == (($past(updCtrNow) == 2'b00) ? 2'b00 : $past(updCtrNow) - 2'd1)));
endmodule

bind gshare_predictor gshare_predictor_chk #(.HIST_BITS(HIST_BITS), .PC_W(PC_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .lookupPc  (lookupPc),
  .predTaken (predTaken),
  .predIdx   (predIdx),
  .updValid  (updValid),
  .updTaken  (updTaken),
  .updIdx    (updIdx),
  .updCtrNow (updCtrNow)
);

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb_top;
  localparam int N     = 8;
  localparam int PC_W  = 32;
  localparam int DEPTH = 1 << N;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic          predTaken;
  logic [N-1:0]  predIdx;
  logic          updValid = 1'b0;
  logic          updTaken = 1'b0;
  logic [N-1:0]  updIdx = '0;

  int checks = 0;
  int fails  = 0;

  logic [1:0]   mCtr [DEPTH];
  logic [N-1:0] mHist;

  always #5 clk = ~clk;

  gshare_predictor #(.HIST_BITS(N), .PC_W(PC_W)) dut_i (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .predIdx(predIdx), .updValid(updValid), .updTaken(updTaken), .updIdx(updIdx)
  );

  function automatic logic [1:0] satStep(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? 2'b11 : c + 2'd1;
    return (c == 2'b00) ? 2'b00 : c - 2'd1;
  endfunction

  function automatic logic [PC_W-1:0] pcFor(logic [N-1:0] idx, logic [PC_W-1:0] noise);
    logic [PC_W-1:0] p;
    p = noise;
    p[N+1:2] = idx ^ mHist;
    return p;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // drive at negedge, compare combinational outputs, then let the edge update
  task automatic step(string req, logic [PC_W-1:0] pc, logic v, logic t, logic [N-1:0] ui);
    logic [N-1:0] eIdx;
    @(negedge clk);
    lookupPc = pc; updValid = v; updTaken = t; updIdx = ui;
    #1;
    eIdx = pc[N+1:2] ^ mHist;
    chk({req, " R2 index"}, int'(predIdx), int'(eIdx));
    chk({req, " R3 prediction"}, int'(predTaken), int'(mCtr[eIdx][1]));
    @(posedge clk);
    if (v) begin
      mCtr[ui] = satStep(mCtr[ui], t);
      mHist = {mHist[N-2:0], t};
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] tgt;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mCtr[i] = (i % 2 == 1) ? 2'b10 : 2'b01;
    mHist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset pattern, every entry with zero history
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      lookupPc = PC_W'(i) << 2; updValid = 1'b0;
      #1;
      chk("R1 reset history", int'(predIdx), i);
      chk("R1 reset counter", int'(predTaken), i % 2);
    end

    // R2: low two bits and upper bits ignored
    step("R2 noise", pcFor(8'd5, 32'hFFFF_FC03), 1'b0, 1'b0, '0);
    step("R2 noise", pcFor(8'd6, 32'hA5A5_0002), 1'b0, 1'b0, '0);

    // R4: train entry 7 taken past saturation, history moves each time
    tgt = 8'd7;
    for (int k = 0; k < 4; k++) step("R4 saturate up", pcFor(tgt, '0), 1'b1, 1'b1, tgt);
    step("R4 at 11", pcFor(tgt, '0), 1'b0, 1'b0, '0);
    chk("R4 predict taken at 11", int'(predTaken), 1);

    // R5: down past 00, then one taken keeps not-taken (hysteresis)
    for (int k = 0; k < 5; k++) step("R5 saturate down", pcFor(tgt, '0), 1'b1, 1'b0, tgt);
    step("R5 one up from 00", pcFor(tgt, '0), 1'b1, 1'b1, tgt);
    step("R5 hysteresis", pcFor(tgt, '0), 1'b0, 1'b0, '0);
    chk("R5 still not taken at 01", int'(predTaken), 0);

    // R8: same-cycle lookup and update of one entry sees the old value
    tgt = 8'd20;
    step("R8 same entry", pcFor(tgt, '0), 1'b1, 1'b1, tgt);
    chk("R8 old value visible", int'(predTaken), 0);
    step("R8 after update", pcFor(tgt, '0), 1'b0, 1'b0, '0);
    chk("R8 new value visible", int'(predTaken), 1);

    // R7: update inputs toggle without valid; history and counters hold
    for (int k = 0; k < 6; k++) step("R7 no valid", pcFor(tgt, 32'h0000_1000), 1'b0, 1'b1, tgt);
    chk("R7 entry unchanged", int'(predTaken), 1);

    // R9: update elsewhere leaves neighbour untouched
    step("R9 update other", pcFor(tgt, '0), 1'b1, 1'b0, tgt + 8'd1);
    step("R9 neighbour kept", pcFor(tgt, '0), 1'b0, 1'b0, '0);

    // random traffic, R6 history tracked by the model
    for (int k = 0; k < 4000; k++) begin
      logic [PC_W-1:0] pc;
      logic [N-1:0]    ui;
      pc = $urandom;
      ui = ($urandom_range(0, 3) == 0) ? (pc[N+1:2] ^ mHist) : N'($urandom_range(0, 15));
      step("R6 random", pc, $urandom_range(0, 9) < 7, 1'($urandom), ui);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule